// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block turns one stream of timing events into three banks of four clock outputs plus one feedback output. Each bank and the feedback path has its own even divide ratio, picked by a small select code. The banks can therefore run at different frequency ratios to each other and to the source. Everything runs in one system clock domain. The fast source and the reference source each arrive as a single-cycle tick strobe. A divider advances only on a tick taken from the chosen source. An optional pre-scale halves the tick rate before the dividers.

One active-low input does two jobs. While it is low, every divide counter is held cleared, every output-enable is deasserted (the high-impedance state) and the select codes are captured. While it is high, the outputs are driven and the captured codes stay frozen. A select change made while running therefore has no effect until the next reset. The two upper outputs of bank C can be inverted at any time by a live control input.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A divides the advance count by 4, 6, 8 or 12 for sel_a_i = 0, 1, 2, 3.
- R2: Bank B divides the advance count by 4, 6, 8 or 10 for sel_b_i = 0, 1, 2, 3.
- R3: Bank C divides the advance count by 2, 4, 6 or 8 for sel_c_i = 0, 1, 2, 3.
- R4: The feedback output divides by 4, 6, 8 or 10 when sel_fb_i[2] is 0, and by 8, 12, 16 or 20 when it is 1, indexed by sel_fb_i[1:0].
- R5: Every output of ratio N is high while (advance count mod N) < N/2 and low otherwise. This gives a 50 % duty cycle. All banks are high in the first cycle after reset release, so their rising edges are aligned.
- R6: When inv_c_i is 1, bank_c_o[3:2] are the complement of bank_c_o[1:0]. When it is 0, they are equal. The input acts immediately.
- R7: While en_rstn is low, all 13 bits of oe_o are 0 and all counters are cleared. While it is high, all bits of oe_o are 1. The bits of oe_o are ordered A[3:0], B[3:0], C[3:0] and then feedback at bit 12.
- R8: When use_fast_i was 1 at the last reset, fast_tick_i supplies the ticks and ref_tick_i is ignored. When it was 0, the roles are swapped.
- R9: When full_rate_i was 1 at the last reset, every selected tick is an advance. When it was 0, only the 2nd, 4th, 6th and later even-numbered selected ticks after reset are advances.
- R10: The select codes, use_fast_i and full_rate_i are sampled only on clock edges where en_rstn is low. Changes while running have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| en_rstn | input | 1 | Active-low counter clear and output disable |
| fast_tick_i | input | 1 | Fast-source tick strobe |
| ref_tick_i | input | 1 | Reference-source tick strobe |
| use_fast_i | input | 1 | 1 selects fast ticks, 0 selects reference ticks |
| full_rate_i | input | 1 | 1 uses every tick, 0 halves the tick rate |
| sel_a_i | input | 2 | Bank A ratio code |
| sel_b_i | input | 2 | Bank B ratio code |
| sel_c_i | input | 2 | Bank C ratio code |
| sel_fb_i | input | 3 | Feedback ratio code |
| inv_c_i | input | 1 | Invert bank C outputs 3 and 2 |
| bank_a_o | output | 4 | Bank A clocks |
| bank_b_o | output | 4 | Bank B clocks |
| bank_c_o | output | 4 | Bank C clocks |
| fb_o | output | 1 | Feedback clock |
| oe_o | output | 13 | Per-output drive enables |

## Verification
A tick presented before a clock edge moves the divider outputs in the cycle that edge starts. oe_o and the bank C inversion are combinational and follow their inputs within the same cycle. The bench's driver task computes the expected vector of all outputs and enables for the edge that follows each stimulus and queues it. The monitor takes each queued item 2 ns after that edge and compares it, so every result is checked exactly one register stage after its cause.

// File: rtl/clkdiv_banks.sv
module clkdiv_banks #(
  parameter int CNT_W  = 5,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              en_rstn,
  input  logic              fast_tick_i,
  input  logic              ref_tick_i,
  input  logic              use_fast_i,
  input  logic              full_rate_i,
  input  logic [1:0]        sel_a_i,
  input  logic [1:0]        sel_b_i,
  input  logic [1:0]        sel_c_i,
  input  logic [2:0]        sel_fb_i,
  input  logic              inv_c_i,
  output logic [BANK_W-1:0] bank_a_o,
  output logic [BANK_W-1:0] bank_b_o,
  output logic [BANK_W-1:0] bank_c_o,
  output logic              fb_o,
  output logic [3*BANK_W:0] oe_o
);
  localparam int NDIV = 4;

  logic [1:0] sa_q, sb_q, sc_q;
  logic [2:0] sf_q;
  logic       fast_q, full_q, ph_q;

  always_ff @(posedge clk)
    if (!en_rstn) begin
      sa_q   <= sel_a_i;
      sb_q   <= sel_b_i;
      sc_q   <= sel_c_i;
      sf_q   <= sel_fb_i;
      fast_q <= use_fast_i;
      full_q <= full_rate_i;
    end

  wire tick = fast_q ? fast_tick_i : ref_tick_i;
  wire adv  = tick & (full_q | ph_q);

  always_ff @(posedge clk)
    if (!en_rstn)  ph_q <= 1'b0;
    else if (tick) ph_q <= ~ph_q;

  logic [CNT_W-1:0] ratio [NDIV];
  logic [NDIV-1:0]  hi;

  assign ratio[0] = (sa_q == 2'd3) ? CNT_W'(12) : CNT_W'(4) + CNT_W'({sa_q, 1'b0});
  assign ratio[1] = CNT_W'(4) + CNT_W'({sb_q, 1'b0});
  assign ratio[2] = CNT_W'(2) + CNT_W'({sc_q, 1'b0});
  assign ratio[3] = sf_q[2] ? CNT_W'(8) + CNT_W'({sf_q[1:0], 2'b00})
                            : CNT_W'(4) + CNT_W'({sf_q[1:0], 1'b0});

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk)
      if (!en_rstn) cnt <= '0;
      else if (adv) cnt <= (cnt == ratio[g] - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
    assign hi[g] = cnt < (ratio[g] >> 1);
  end

  assign bank_a_o = {BANK_W{hi[0]}};
  assign bank_b_o = {BANK_W{hi[1]}};
  assign bank_c_o = {{2{hi[2] ^ inv_c_i}}, {(BANK_W-2){hi[2]}}};
  assign fb_o     = hi[3];
  assign oe_o     = {(3*BANK_W+1){en_rstn}};
endmodule

module clkdiv_banks_chk #(
  parameter int BW = 4
) (
  input logic          clk,
  input logic          en_rstn,
  input logic          fast_tick_i,
  input logic          ref_tick_i,
  input logic          inv_c_i,
  input logic [BW-1:0] a,
  input logic [BW-1:0] b,
  input logic [BW-1:0] c,
  input logic          fb,
  input logic [3*BW:0] oe
);
  // R7
  clear_hold_chk: assert property (@(posedge clk)
    !en_rstn |=> (a == {BW{1'b1}} && b == {BW{1'b1}} && c[1:0] == 2'b11 && fb));

  // R5
  align_start_chk: assert property (@(posedge clk) disable iff (!en_rstn)
    $rose(en_rstn) |-> (a == {BW{1'b1}} && b == {BW{1'b1}} && c[1:0] == 2'b11 && fb && oe == '1));

  // R6
  c_invert_chk: assert property (@(posedge clk) disable iff (!en_rstn)
    c[3:2] == ({2{inv_c_i}} ^ c[1:0]));

  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!en_rstn)
    (!fast_tick_i && !ref_tick_i) |=> $stable({a, b, c[1:0], fb}));
endmodule

bind clkdiv_banks clkdiv_banks_chk #(.BW(BANK_W)) u_chk (
  .clk(clk), .en_rstn(en_rstn), .fast_tick_i(fast_tick_i), .ref_tick_i(ref_tick_i),
  .inv_c_i(inv_c_i), .a(bank_a_o), .b(bank_b_o), .c(bank_c_o), .fb(fb_o), .oe(oe_o));

// File: tb/sim_clkdiv_banks.sv
module sim_clkdiv_banks;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic en_rstn = 1'b0, fast_tick = 1'b0, ref_tick = 1'b0;
  logic use_fast = 1'b1, full_rate = 1'b1, inv_c = 1'b0;
  logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
  logic [2:0] sel_fb = '0;
  logic [3:0] bank_a, bank_b, bank_c;
  logic fb;
  logic [12:0] oe;

  clkdiv_banks u0 (
    .clk(clk), .en_rstn(en_rstn), .fast_tick_i(fast_tick), .ref_tick_i(ref_tick),
    .use_fast_i(use_fast), .full_rate_i(full_rate), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .sel_c_i(sel_c), .sel_fb_i(sel_fb), .inv_c_i(inv_c), .bank_a_o(bank_a),
    .bank_b_o(bank_b), .bank_c_o(bank_c), .fb_o(fb), .oe_o(oe));

  int checks = 0, errors = 0;
  logic [25:0] q_exp[$];
  string q_tag[$];
  string cur_tag = "R7";

  logic [1:0] p_a = 0, p_b = 0, p_c = 0;
  logic [2:0] p_f = 0;
  logic p_fast = 1, p_full = 1, p_inv = 0;
  int m_n = 0, m_ra = 4, m_rb = 4, m_rc = 2, m_rf = 4;
  bit m_ph = 0, m_fast = 1, m_full = 1;

  function automatic int ra_of(input logic [1:0] s);
    case (s) 0: return 4; 1: return 6; 2: return 8; default: return 12; endcase
  endfunction
  function automatic int rb_of(input logic [1:0] s);
    case (s) 0: return 4; 1: return 6; 2: return 8; default: return 10; endcase
  endfunction
  function automatic int rc_of(input logic [1:0] s);
    case (s) 0: return 2; 1: return 4; 2: return 6; default: return 8; endcase
  endfunction
  function automatic int rf_of(input logic [2:0] s);
    case (s)
      0: return 4;  1: return 6;  2: return 8;  3: return 10;
      4: return 8;  5: return 12; 6: return 16; default: return 20;
    endcase
  endfunction
  function automatic bit hi_of(input int n, input int r);
    return (n % r) < (r / 2);
  endfunction

  task automatic step(input logic rn, input logic ft, input logic rt);
    bit t, ha, hb, hc, hf, ic;
    @(negedge clk);
    sel_a = p_a; sel_b = p_b; sel_c = p_c; sel_fb = p_f;
    use_fast = p_fast; full_rate = p_full; inv_c = p_inv;
    en_rstn = rn; fast_tick = ft; ref_tick = rt;
    if (!rn) begin
      m_n = 0; m_ph = 0;
      m_ra = ra_of(p_a); m_rb = rb_of(p_b); m_rc = rc_of(p_c); m_rf = rf_of(p_f);
      m_fast = p_fast; m_full = p_full;
    end else begin
      t = m_fast ? ft : rt;
      if (t) begin
        if (m_full || m_ph) m_n++;
        m_ph = !m_ph;
      end
    end
    ha = hi_of(m_n, m_ra); hb = hi_of(m_n, m_rb);
    hc = hi_of(m_n, m_rc); hf = hi_of(m_n, m_rf);
    ic = hc ^ p_inv;
    q_exp.push_back({{13{rn}}, hf, ic, ic, hc, hc, {4{hb}}, {4{ha}}});
    q_tag.push_back(cur_tag);
  endtask

  task automatic run(input int n, input int fp, input int rp);
    for (int i = 0; i < n; i++) step(1'b1, (i % fp) == 0, (i % rp) == 0);
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b1);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [25:0] e, g;
      string tg;
      e = q_exp.pop_front();
      tg = q_tag.pop_front();
      g = {oe, fb, bank_c, bank_b, bank_a};
      checks++;
      if (g !== e) begin
        errors++;
        $display("FAIL %s got %h expected %h", tg, g, e);
      end
    end
  end

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_tag = "R7 reset state";
    do_reset(4);
    cur_tag = "R1 R2 R3 R4 R5 smallest ratios";
    run(40, 1, 1000);
    p_a = 3; p_b = 3; p_c = 3; p_f = 7;
    cur_tag = "R7 reset";
    do_reset(2);
    cur_tag = "R1 R2 R3 R4 R5 largest ratios";
    run(60, 1, 7);
    p_a = 1; p_b = 2; p_c = 2; p_f = 5;
    do_reset(2);
    cur_tag = "R6 inversion";
    run(20, 1, 1);
    p_inv = 1; run(20, 1, 1);
    p_inv = 0; run(5, 1, 1);
    cur_tag = "R10 select change while running";
    p_a = 0; p_b = 1; p_c = 1; p_f = 2;
    run(30, 1, 1);
    do_reset(1);
    cur_tag = "R10 select taken at reset";
    run(30, 1, 1);
    cur_tag = "R8 reference source";
    p_fast = 0; p_f = 4;
    do_reset(2);
    run(60, 1, 3);
    run(30, 2, 5);
    cur_tag = "R9 half rate";
    p_full = 0; p_fast = 1; p_f = 3;
    do_reset(2);
    run(60, 1, 1);
    p_fast = 0;
    do_reset(1);
    run(40, 3, 2);
    cur_tag = "R7 mid-run reset";
    p_full = 1; p_fast = 1;
    do_reset(3);
    cur_tag = "R7 outputs driven";
    run(10, 1, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule